// File: doc/BRIEF.md
# Parity-Predicted Ripple Adder with Redundant Carry Chain

This block adds two binary operands and a carry-in. Each operand arrives with one even-parity bit, and the result leaves with one parity bit. The block does not derive the result parity from the sum bits. It predicts that parity from the two operand parity bits and the XOR of the carries that enter each bit position. An error in the adder logic therefore shows up as a mismatch that a separate downstream checker can catch while the adder is in use. That checker is not part of this block.

By default a second carry chain is built. It is independent of the chain that feeds the sum, and it supplies the carries used for prediction. A fault on a main-chain carry then changes the sum without changing the predicted parity. A build-time parameter can remove the redundant chain to save area, and prediction then uses the main chain's own carries. In that cheaper form, a corrupted carry alters both the sum and the prediction in the same way, so the fault stays hidden.

The logic is purely combinational and has no handshake. A debug injection port can override one internal carry of the main chain. It exists to show how the two variants differ in their ability to detect faults.

Top module: `parity_adder`

## Requirements
- R1: With injection off, `{carry_out, sum}` equals `opa + opb + carry_in`.
- R2: With injection off, and each operand parity bit equal to the XOR of its operand's data bits (even convention), `sum_par` equals the XOR of the four `sum` bits.
- R3: With `USE_DUP_CARRY=1`, `sum_par` equals `opa_par ^ opb_par ^ carry_in ^ c1 ^ c2 ^ c3`. Here c1..c3 are the fault-free carries into bit positions 1..3, so forcing a main-chain carry never changes `sum_par`.
- R4: With `USE_DUP_CARRY=1` and correct operand parities, forcing the carry into bit 3 to the opposite of its fault-free value makes `sum_par` differ from the XOR of the `sum` bits.
- R5: With `USE_DUP_CARRY=0`, prediction uses the main-chain carries actually applied. With correct operand parities, `sum_par` therefore equals the XOR of the `sum` bits even under any forced carry.
- R6: When `flt_en` is 1 and `flt_sel` is k in 1..3, the carry into bit k is replaced by `flt_val`, and `sum` and `carry_out` follow the altered ripple. When `flt_sel` is 0, the port has no effect on any output.
- R7: Inverting one operand parity bit inverts `sum_par` and leaves `sum` and `carry_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 4 | First operand data |
| opa_par | input | 1 | Even parity bit of opa |
| opb | input | 4 | Second operand data |
| opb_par | input | 1 | Even parity bit of opb |
| carry_in | input | 1 | Carry into bit 0 |
| flt_en | input | 1 | Enable main-chain carry override (debug) |
| flt_sel | input | 2 | Bit position whose incoming carry is overridden (1..3) |
| flt_val | input | 1 | Value forced onto the selected carry |
| sum | output | 4 | Sum data bits |
| sum_par | output | 1 | Predicted even parity of sum |
| carry_out | output | 1 | Carry out of bit 3, from the main chain |

## Verification
The parity-consistency and detection assertions only apply when both operand parity bits are correct. The arithmetic and carry-agreement assertions only apply while the injection port is idle. The stimulus always computes operand parity from the data. The one exception is a dedicated sweep that inverts one parity bit, and the bench checks that sweep at the ports alone. Injected sweeps drive `flt_en` high on purpose. There the assertions step aside, and the bench compares every output against its own arithmetic model of the altered carry ripple.

// File: rtl/padd_pkg.sv
package padd_pkg;

  localparam int unsigned PADD_DEF_WIDTH = 4;

  // Majority of three: the carry produced by one binary digit position.
  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/padd_fa_cell.sv
module padd_fa_cell
  import padd_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);

  logic half;

  assign half = a ^ b;
  assign s    = half ^ ci;
  assign co   = maj3(a, b, ci);

endmodule

// File: rtl/padd_ripple.sv
module padd_ripple #(
  parameter int unsigned WIDTH = 4,
  localparam int unsigned SELW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             inj_en,
  input  logic [SELW-1:0]  inj_sel,
  input  logic             inj_val,
  output logic [WIDTH-1:0] sum,
  output logic [WIDTH:0]   carries
);

  logic [WIDTH:1] craw;

  assign carries[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i > 0) begin : g_tap
      // Debug override of the carry entering position i.
      assign carries[i] = (inj_en && (inj_sel == SELW'(i))) ? inj_val : craw[i];
    end
    padd_fa_cell u_cell (
      .a  (a[i]),
      .b  (b[i]),
      .ci (carries[i]),
      .s  (sum[i]),
      .co (craw[i+1])
    );
  end

  assign carries[WIDTH] = craw[WIDTH];

  always_comb begin
    if (!inj_en) begin
      AST_SUM_ARITH: assert ({carries[WIDTH], sum} ==
                             ((WIDTH+1)'(a) + (WIDTH+1)'(b) + (WIDTH+1)'(cin)))
        else $error("ripple result disagrees with binary addition"); // R1
    end
  end

endmodule

// File: rtl/padd_carry_dup.sv
module padd_carry_dup
  import padd_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] carries
);

  // Carry-only replica: no sum logic and no override, so its carries are
  // electrically separate from the chain that feeds the sum.
  assign carries[0] = cin;

  for (genvar i = 0; i < WIDTH - 1; i++) begin : g_cy
    assign carries[i+1] = maj3(a[i], b[i], carries[i]);
  end

endmodule

// File: rtl/padd_parity_pred.sv
module padd_parity_pred #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             pa,
  input  logic             pb,
  input  logic [WIDTH-1:0] cy,
  output logic             pred
);

  // Each sum bit is a^b^c, so the XOR over all positions folds to
  // parity(a) ^ parity(b) ^ parity(incoming carries).
  assign pred = pa ^ pb ^ (^cy);

endmodule

// File: rtl/parity_adder.sv
module parity_adder
  import padd_pkg::*;
#(
  parameter int unsigned WIDTH         = PADD_DEF_WIDTH,
  parameter bit          USE_DUP_CARRY = 1'b1,
  localparam int unsigned SELW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] opa,
  input  logic             opa_par,
  input  logic [WIDTH-1:0] opb,
  input  logic             opb_par,
  input  logic             carry_in,
  input  logic             flt_en,
  input  logic [SELW-1:0]  flt_sel,
  input  logic             flt_val,
  output logic [WIDTH-1:0] sum,
  output logic             sum_par,
  output logic             carry_out
);

  logic [WIDTH:0]   main_c;
  logic [WIDTH-1:0] pred_c;
  logic             par_ok;

  padd_ripple #(.WIDTH(WIDTH)) u_main (
    .a       (opa),
    .b       (opb),
    .cin     (carry_in),
    .inj_en  (flt_en),
    .inj_sel (flt_sel),
    .inj_val (flt_val),
    .sum     (sum),
    .carries (main_c)
  );

  assign carry_out = main_c[WIDTH];

  if (USE_DUP_CARRY) begin : g_dup
    logic [WIDTH-1:0] dup_c;

    padd_carry_dup #(.WIDTH(WIDTH)) u_dup (
      .a       (opa),
      .b       (opb),
      .cin     (carry_in),
      .carries (dup_c)
    );
    assign pred_c = dup_c;

    always_comb begin
      if (!flt_en) begin
        AST_CARRY_MATCH: assert (dup_c == main_c[WIDTH-1:0])
          else $error("redundant carries diverge from main chain"); // R3
      end
      if (flt_en && (flt_sel == SELW'(WIDTH-1)) && (flt_val != dup_c[WIDTH-1]) && par_ok) begin
        AST_DETECT_LAST: assert (sum_par != (^sum))
          else $error("forced top carry went undetected"); // R4
      end
    end
  end else begin : g_red
    assign pred_c = main_c[WIDTH-1:0];

    always_comb begin
      if (par_ok) begin
        AST_REDUCED_HIDES: assert (sum_par == (^sum))
          else $error("reduced variant parity inconsistent"); // R5
      end
    end
  end

  padd_parity_pred #(.WIDTH(WIDTH)) u_pred (
    .pa   (opa_par),
    .pb   (opb_par),
    .cy   (pred_c),
    .pred (sum_par)
  );

  assign par_ok = (opa_par == (^opa)) && (opb_par == (^opb));

  always_comb begin
    if (!flt_en && par_ok) begin
      AST_PARITY_CONSISTENT: assert (sum_par == (^sum))
        else $error("predicted parity does not match sum"); // R2
    end
  end

endmodule

// File: tb/tb_parity_adder.sv
`timescale 1ns/1ps
module tb_parity_adder;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] opa, opb;
  logic       opa_par, opb_par, carry_in, flt_en, flt_val;
  logic [1:0] flt_sel;
  logic [3:0] sum_d, sum_r;
  logic       par_d, par_r, co_d, co_r;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  parity_adder #(.WIDTH(4), .USE_DUP_CARRY(1'b1)) dut (
    .opa(opa), .opa_par(opa_par), .opb(opb), .opb_par(opb_par),
    .carry_in(carry_in), .flt_en(flt_en), .flt_sel(flt_sel), .flt_val(flt_val),
    .sum(sum_d), .sum_par(par_d), .carry_out(co_d)
  );

  parity_adder #(.WIDTH(4), .USE_DUP_CARRY(1'b0)) dut_red (
    .opa(opa), .opa_par(opa_par), .opb(opb), .opb_par(opb_par),
    .carry_in(carry_in), .flt_en(flt_en), .flt_sel(flt_sel), .flt_val(flt_val),
    .sum(sum_r), .sum_par(par_r), .carry_out(co_r)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (a=%0d b=%0d ci=%0d fen=%0d fsel=%0d fval=%0d)",
               tag, act, exp, opa, opb, carry_in, flt_en, flt_sel, flt_val);
    end
  endtask

  // Arithmetic model: returns sum, carry-out, XOR of applied carries 0..3,
  // XOR of fault-free carries 0..3, and the fault-free carry into bit 3.
  task automatic model(input logic [3:0] a, input logic [3:0] b, input logic ci,
                       input logic fen, input int fsel, input logic fval,
                       output logic [3:0] s, output logic co,
                       output logic x_used, output logic x_true, output logic c3_true);
    logic cu, ct;
    cu = ci; ct = ci; x_used = 1'b0; x_true = 1'b0; c3_true = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (i > 0 && fen && fsel == i) cu = fval;
      if (i == 3) c3_true = ct;
      x_used ^= cu;
      x_true ^= ct;
      s[i] = a[i] ^ b[i] ^ cu;
      cu = (a[i] & b[i]) | (a[i] & cu) | (b[i] & cu);
      ct = (a[i] & b[i]) | (a[i] & ct) | (b[i] & ct);
    end
    co = cu;
  endtask

  task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic ci,
                       input logic fen, input logic [1:0] fsel, input logic fval,
                       input logic flip_pa);
    logic [3:0] es; logic eco, xu, xt, c3t, pa, pb;
    @(posedge clk);
    pa = (^a) ^ flip_pa; pb = ^b;
    opa = a; opb = b; carry_in = ci; opa_par = pa; opb_par = pb;
    flt_en = fen; flt_sel = fsel; flt_val = fval;
    @(negedge clk);
    model(a, b, ci, fen, int'(fsel), fval, es, eco, xu, xt, c3t);
    if (!fen) begin
      chk({co_d, sum_d} == {eco, es}, "R1 dup sum", {co_d, sum_d}, {eco, es});
      chk({co_r, sum_r} == {eco, es}, "R1 red sum", {co_r, sum_r}, {eco, es});
    end else begin
      chk({co_d, sum_d} == {eco, es}, "R6 dup forced sum", {co_d, sum_d}, {eco, es});
      chk({co_r, sum_r} == {eco, es}, "R6 red forced sum", {co_r, sum_r}, {eco, es});
    end
    if (flip_pa) begin
      chk(par_d == ~(pa ^ 1'b1 ^ pb ^ xt) ? 1'b1 : 1'b0, "R7 dup parity flip", par_d, pa ^ pb ^ xt);
      chk(par_r == (pa ^ pb ^ xu), "R7 red parity flip", par_r, pa ^ pb ^ xu);
    end else begin
      chk(par_d == (pa ^ pb ^ xt), "R3 dup prediction", par_d, pa ^ pb ^ xt);
      chk(par_r == (^sum_r), "R5 red consistent", par_r, ^sum_r);
      if (!fen)
        chk(par_d == (^sum_d), "R2 dup consistent", par_d, ^sum_d);
      if (fen && fsel == 2'd3 && fval != c3t)
        chk(par_d != (^sum_d), "R4 dup detects", par_d, ~(^sum_d));
    end
  endtask

  initial begin
    opa = '0; opb = '0; opa_par = 0; opb_par = 0; carry_in = 0;
    flt_en = 0; flt_sel = '0; flt_val = 0;
    @(negedge clk);
    chk(sum_d == 4'd0 && co_d == 1'b0 && par_d == 1'b0, "R1 idle zero", {co_d, sum_d, par_d}, 0);
    // Fault-free exhaustive sweep
    for (int v = 0; v < 512; v++)
      apply(v[3:0], v[7:4], v[8], 1'b0, 2'd0, 1'b0, 1'b0);
    // Inverted operand parity sweep
    for (int v = 0; v < 512; v++)
      apply(v[3:0], v[7:4], v[8], 1'b0, 2'd0, 1'b0, 1'b1);
    // Carry override on every position, both values; position 0 must be inert
    for (int k = 0; k < 4; k++)
      for (int fv = 0; fv < 2; fv++)
        for (int v = 0; v < 512; v++)
          apply(v[3:0], v[7:4], v[8], 1'b1, 2'(k), fv[0], 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule